// File: doc/BRIEF.md
# Two-Stage SCL Clock Generator

This block produces the serial clock timing for a two-wire bus master from the fast peripheral clock. One 8-bit control word sets both stages. The low two bits choose a prescale value. The prescaler turns that value into an internal slot enable that fires once every (prescale + 1) clock cycles. The upper six bits choose a divider value. The phase counter steps once per slot and wraps after 8 × divider + 20 slots. That count is one SCL period.

While the generator is enabled, it drives a free-running SCL phase output and four one-cycle ticks: one at the start of the high half, one in the middle of the high half, one at the start of the low half and one in the middle of the low half. The master engine uses these ticks to place its data setup and hold. A new control word is applied only when a period ends. While the generator is disabled, SCL rests high and no tick is produced. All outputs are registered.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `scl_o` is 1 and `tick_o` is all zeros.
- R2: The prescale field is `cfg_i[1:0]` (value p) and the divider field is `cfg_i[7:2]` (value d). Consecutive period starts are (8·d + 20)·(p + 1) clock cycles apart for every d from 0 to 63 and every p from 0 to 3.
- R3: Let P = 8·d + 20 be the period in slots. Each period holds `scl_o` at 1 for floor(P/2) slots, which is floor(P/2)·(p + 1) clock cycles. `scl_o` is 0 for the remaining slots, so an odd P gives the extra slot to the low half.
- R4: Let H = floor(P/2) and L = P − H. Each `tick_o` bit is high for exactly one clock cycle per period, at the first cycle of a fixed slot: bit 0 at slot 0, bit 1 at slot floor(H/2), bit 2 at slot H and bit 3 at slot H + floor(L/2). Bit 0 coincides with the first cycle of the high half.
- R5: A change of `cfg_i` during a period does not alter that period. The new setting applies from the next period start.
- R6: While `en_i` is 0, `scl_o` is 1 and `tick_o` is zero, whatever `cfg_i` holds.
- R7: When `en_i` is sampled 1 after being 0, a period starts at once. `tick_o[0]` and a high `scl_o` appear in the cycle after that sampling edge, using the `cfg_i` value present while the generator was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral module clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; 0 holds SCL idle high |
| cfg_i | input | 8 | Control word: [1:0] prescale, [7:2] SCL divider |
| scl_o | output | 1 | Registered SCL phase, 1 during the high half |
| tick_o | output | 4 | One-cycle ticks: [0] high start, [1] high middle, [2] low start, [3] low middle |

## Verification
A wrong prescale count or a wrong wrap point of the phase counter stretches or shrinks the distance between `tick_o[0]` pulses. That shows within the first full period after enable, at most 2096 cycles. A wrong half-point comparison moves the falling edge of `scl_o` or one of the inner ticks, so the high-time and tick-offset measurements catch it in the same period. If the shadow copy of the control word were loaded too early, the period in which `cfg_i` changes would already measure the new length. That shows at the first period boundary after the write.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int NUM_TICKS = 4;

  typedef enum logic [1:0] {
    TK_HI_START = 2'd0,
    TK_HI_MID   = 2'd1,
    TK_LO_START = 2'd2,
    TK_LO_MID   = 2'd3
  } tick_idx_e;
endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             slot_end_o,
  output logic             slot_first_o
);
  logic [PRE_W-1:0] pre_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pre_cnt <= '0;
    end else if (pre_cnt == pre_i) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  assign slot_end_o   = en_i && (pre_cnt == pre_i);
  assign slot_first_o = en_i && (pre_cnt == '0);

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= pre_i);
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 6,
  parameter int STEP  = 8,
  parameter int BASE  = 20,
  localparam int CFG_W = PRE_W + DIV_W,
  localparam int PER_W = $clog2(STEP * (2**DIV_W - 1) + BASE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             slot_end_i,
  output logic [PRE_W-1:0] pre_o,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] hi_o,
  output logic [PER_W-1:0] lo_o
);
  logic [CFG_W-1:0] shadow;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] per;
  logic [DIV_W-1:0] div;
  logic             wrap;

  assign div   = shadow[CFG_W-1:PRE_W];
  assign pre_o = shadow[PRE_W-1:0];
  assign per   = PER_W'(div) * PER_W'(STEP) + PER_W'(BASE);
  assign hi_o  = per >> 1;
  assign lo_o  = per - (per >> 1);
  assign wrap  = slot_end_i && (cnt == per - 1'b1);
  assign cnt_o = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      cnt    <= '0;
    end else if (!en_i) begin
      shadow <= cfg_i;
      cnt    <= '0;
    end else if (wrap) begin
      shadow <= cfg_i;
      cnt    <= '0;
    end else if (slot_end_i) begin
      cnt    <= cnt + 1'b1;
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < per);

  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && $past(en_i) && !$past(wrap) && !$past(rst)) |-> $stable(shadow));
endmodule

// File: rtl/scl_tick_out.sv
module scl_tick_out
  import scl_div_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 slot_first_i,
  input  logic [PER_W-1:0]     cnt_i,
  input  logic [PER_W-1:0]     hi_i,
  input  logic [PER_W-1:0]     lo_i,
  output logic                 scl_o,
  output logic [NUM_TICKS-1:0] tick_o
);
  logic [PER_W-1:0] tgt [NUM_TICKS];

  assign tgt[TK_HI_START] = '0;
  assign tgt[TK_HI_MID]   = hi_i >> 1;
  assign tgt[TK_LO_START] = hi_i;
  assign tgt[TK_LO_MID]   = hi_i + (lo_i >> 1);

  always_ff @(posedge clk) begin
    if (rst) scl_o <= 1'b1;
    else     scl_o <= !en_i || (cnt_i < hi_i);
  end

  for (genvar i = 0; i < NUM_TICKS; i++) begin : g_tick
    always_ff @(posedge clk) begin
      if (rst) tick_o[i] <= 1'b0;
      else     tick_o[i] <= en_i && slot_first_i && (cnt_i == tgt[i]);
    end
  end

  assert_tick_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tick_o));

  assert_fall_at_lo_start_R3: assert property (@(posedge clk) disable iff (rst)
    tick_o[TK_LO_START] |-> (!scl_o && $past(scl_o)));

  assert_rise_at_hi_start_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o[TK_HI_START] |-> scl_o);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_div_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int DIV_W = 6,
  parameter int STEP  = 8,
  parameter int BASE  = 20,
  localparam int CFG_W = PRE_W + DIV_W,
  localparam int PER_W = $clog2(STEP * (2**DIV_W - 1) + BASE + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [CFG_W-1:0]     cfg_i,
  output logic                 scl_o,
  output logic [NUM_TICKS-1:0] tick_o
);
  logic [PRE_W-1:0] pre;
  logic             slot_end;
  logic             slot_first;
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] hi;
  logic [PER_W-1:0] lo;

  scl_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .pre_i        (pre),
    .slot_end_o   (slot_end),
    .slot_first_o (slot_first)
  );

  scl_phase_cnt #(.PRE_W(PRE_W), .DIV_W(DIV_W), .STEP(STEP), .BASE(BASE)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .cfg_i      (cfg_i),
    .slot_end_i (slot_end),
    .pre_o      (pre),
    .cnt_o      (cnt),
    .hi_o       (hi),
    .lo_o       (lo)
  );

  scl_tick_out #(.PER_W(PER_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .slot_first_i (slot_first),
    .cnt_i        (cnt),
    .hi_i         (hi),
    .lo_i         (lo),
    .scl_o        (scl_o),
    .tick_o       (tick_o)
  );

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (scl_o && tick_o == '0));

  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && !$past(en_i) && !$past(rst)) |=> tick_o[TK_HI_START]);
endmodule

// File: tb/scl_clkgen_tb.sv
`timescale 1ns/1ps
module scl_clkgen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       scl;
  logic [3:0] tick;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  scl_clkgen dut_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en),
    .cfg_i  (cfg),
    .scl_o  (scl),
    .tick_o (tick)
  );

  function automatic int slots_of(input int d);
    return 8 * d + 20;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge where tick[0] is 1; returns at the next tick[0].
  task automatic measure(input int chg_at, input logic [7:0] chg_val,
                         output int per, output int hi,
                         output int o1, output int o2, output int o3,
                         output int n0, output int n1, output int n2, output int n3);
    int c;
    c = 0; hi = 0; o1 = -1; o2 = -1; o3 = -1;
    n0 = 1; n1 = 0; n2 = 0; n3 = 0;
    if (scl) hi++;
    forever begin
      if (c == chg_at) cfg = chg_val;
      @(negedge clk);
      c++;
      if (tick[0]) break;
      if (c > 5000) begin
        check("R2", "period timeout", c, 0);
        break;
      end
      if (scl) hi++;
      if (tick[1]) begin n1++; o1 = c; end
      if (tick[2]) begin n2++; o2 = c; end
      if (tick[3]) begin n3++; o3 = c; end
    end
    per = c;
  endtask

  task automatic verify(input int p, input int d, input int per, input int hi,
                        input int o1, input int o2, input int o3,
                        input int n1, input int n2, input int n3);
    int ps, hs, ls;
    ps = slots_of(d);
    hs = ps / 2;
    ls = ps - hs;
    check("R2", "period cycles", per, ps * (p + 1));
    check("R3", "high cycles", hi, hs * (p + 1));
    check("R4", "tick1 offset", o1, (hs / 2) * (p + 1));
    check("R4", "tick2 offset", o2, hs * (p + 1));
    check("R4", "tick3 offset", o3, (hs + ls / 2) * (p + 1));
    check("R4", "tick pulse counts", n1 * 100 + n2 * 10 + n3, 111);
  endtask

  task automatic start_cfg(input int p, input int d);
    en = 1'b0;
    cfg = {d[5:0], p[1:0]};
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    check("R7", "tick0 after enable", int'(tick[0]), 1);
    check("R7", "scl high after enable", int'(scl), 1);
  endtask

  task automatic run_cfg(input int p, input int d);
    int per, hi, o1, o2, o3, n0, n1, n2, n3;
    start_cfg(p, d);
    measure(-1, 8'h00, per, hi, o1, o2, o3, n0, n1, n2, n3);
    verify(p, d, per, hi, o1, o2, o3, n1, n2, n3);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int per, hi, o1, o2, o3, n0, n1, n2, n3;
    int seen;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check("R1", "scl in reset", int'(scl), 1);
    check("R1", "tick in reset", int'(tick), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "scl after reset", int'(scl), 1);
    check("R1", "tick after reset", int'(tick), 0);

    // R6: disabled with changing cfg stays idle
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      cfg = 8'($urandom);
      @(negedge clk);
      if (!scl || tick != 4'd0) seen++;
    end
    check("R6", "idle violations while disabled", seen, 0);

    // directed corners R2
    run_cfg(0, 0);
    run_cfg(3, 62);
    run_cfg(3, 63);
    run_cfg(0, 63);
    run_cfg(2, 1);
    run_cfg(1, 0);

    // random sweep R2
    for (int k = 0; k < 10; k++) begin
      int rp, rd;
      rp = int'($urandom_range(3, 0));
      rd = int'($urandom_range(62, 0));
      run_cfg(rp, rd);
    end

    // R5: change mid-period, takes effect at next boundary
    start_cfg(1, 3);
    measure(5, {6'd10, 2'd2}, per, hi, o1, o2, o3, n0, n1, n2, n3);
    check("R5", "period during change keeps old", per, slots_of(3) * 2);
    measure(-1, 8'h00, per, hi, o1, o2, o3, n0, n1, n2, n3);
    check("R5", "next period uses new", per, slots_of(10) * 3);
    verify(2, 10, per, hi, o1, o2, o3, n1, n2, n3);

    // R6: disable mid-period returns to idle
    repeat (17) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!scl || tick != 4'd0) seen++;
    end
    check("R6", "idle after disable", seen + (scl ? 0 : 1), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule